// File: doc/BRIEF.md
# E1 Performance Error Counter Bank

This block keeps running totals of four kinds of line and framing errors on a 2.048 Mbit/s E1 link. Each error arrives as a single-cycle pulse from upstream detection logic: errored frame alignment words, bipolar line code violations, CRC-4 block errors and far-end block errors carried in the E-bits. Every kind has its own live counter of fixed width. Each counter wraps silently, and each wrap is recorded in a sticky overflow latch.

A prescaler counts frame-rate strobes (one strobe per 125 us frame) and makes a one-second tick from them. On every tick, all four live counters are copied into snapshot registers in the same cycle. The live counters keep running after the copy. The tick also produces a one-second interrupt pulse. The framing error counter drives two interrupts of its own: one on every change of its least significant bit, and one on its wrap. The bipolar violation counter drives an interrupt on its wrap.

A small register port lets software read any live counter, any snapshot or the overflow latch. A read of the overflow latch clears it. A write to a live counter address clears that counter.

Top module: `e1_perf_counters`

## Requirements
- R1: After reset, every live counter, snapshot, overflow bit and interrupt output is zero.
- R2: Each error pulse adds one to its live counter. The counter widths are 8 bits for framing errors, 16 bits for bipolar violations, and 10 bits each for CRC-4 errors and E-bit errors. The live counters read at address 0 (framing), 1 (bipolar), 2 (CRC-4) and 3 (E-bit). Read data on `reg_rdata_o` is combinational and zero-extended to 16 bits.
- R3: A write to address 0 to 3 clears only that live counter. The clear takes effect in the next cycle and wins over an error pulse in the same cycle.
- R4: `fas_lsb_irq_o` is high for exactly the one cycle after any change of bit 0 of the framing error counter, whether the change comes from an increment or from a clear.
- R5: `fas_wrap_irq_o` pulses for one cycle when the framing counter increments from FFh to 00h. `bpv_wrap_irq_o` pulses for one cycle when the bipolar counter increments from FFFFh to 0000h.
- R6: A wrap of any counter sets its bit in the overflow latch at address 8: bit 0 framing, bit 1 bipolar, bit 2 CRC-4, bit 3 E-bit. A read strobe at address 8 returns the latch and then clears it. A wrap in the same cycle as that read stays set.
- R7: A one-second tick occurs on every FRAMES_PER_SEC-th frame strobe (default 8000). `sec_irq_o` is high for the single cycle after the strobe that completes the count.
- R8: On a tick, all four live counters are copied to snapshots at addresses 4 (framing), 5 (bipolar), 6 (CRC-4) and 7 (E-bit). An error pulse in the tick cycle is left out of the snapshot and is counted in the live counter.
- R9: A tick does not clear the live counters. A snapshot holds its value until the next tick, and writes to snapshot addresses have no effect.
- R10: Addresses 9 to 15 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_strobe_i | input | 1 | One pulse per received frame |
| fas_err_i | input | 1 | Errored frame alignment word pulse |
| bpv_err_i | input | 1 | Bipolar violation pulse |
| crc_err_i | input | 1 | CRC-4 block error pulse |
| ebit_err_i | input | 1 | Far-end block error (E-bit) pulse |
| reg_addr_i | input | 4 | Register address |
| reg_rd_i | input | 1 | Read strobe (clears overflow latch at address 8) |
| reg_wr_i | input | 1 | Write strobe (clears live counter at address 0 to 3) |
| reg_rdata_o | output | 16 | Read data |
| fas_lsb_irq_o | output | 1 | Framing counter bit 0 changed |
| fas_wrap_irq_o | output | 1 | Framing counter wrapped |
| bpv_wrap_irq_o | output | 1 | Bipolar counter wrapped |
| sec_irq_o | output | 1 | One-second tick occurred |

## Verification
The embedded assertions check on every cycle the rules that hold locally:
- an increment adds exactly one;
- a clear leaves zero;
- a snapshot equals the live value from the cycle before the tick;
- a wrap pulse always comes with a zero count and a set overflow bit;
- the prescaler stays inside its range.

The directed scenarios show the rules that only appear across long runs or need the register port:
- full wraps of the 8-, 10- and 16-bit counters;
- clear-on-read combined with a wrap in the same cycle;
- priority of a clear over an error pulse in the same cycle;
- the exact strobe count per tick;
- exclusion of a same-cycle error from the snapshot.

// File: rtl/e1pm_pkg.sv
package e1pm_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int N_CNT    = 4;
  localparam int IDX_FAS  = 0;
  localparam int IDX_BPV  = 1;
  localparam int IDX_CRC  = 2;
  localparam int IDX_EBIT = 3;
  localparam logic [ADDR_W-1:0] ADDR_SNAP_BASE = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_OVF       = 4'd8;
endpackage

// File: rtl/e1pm_prescaler.sv
module e1pm_prescaler #(
  parameter int FRAMES_PER_SEC = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic tick_o
);
  localparam int PS_W = $clog2(FRAMES_PER_SEC + 1);
  localparam logic [PS_W-1:0] LAST = PS_W'(FRAMES_PER_SEC - 1);

  logic [PS_W-1:0] cnt_q;

  assign tick_o = strobe_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else if (strobe_i) cnt_q <= cnt_q + 1'b1;
  end

  assert_prescale_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_prescale_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(cnt_q));
endmodule

// File: rtl/e1pm_counter.sv
module e1pm_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         clr_i,
  input  logic         snap_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] snap_o,
  output logic         wrap_now_o,
  output logic         wrap_o,
  output logic         lsb_tgl_o
);
  logic [W-1:0] cnt_q, snap_q, cnt_d;
  logic         wrap_q, tgl_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)      cnt_d = '0;
    else if (inc_i) cnt_d = cnt_q + 1'b1;
  end

  assign wrap_now_o = inc_i && !clr_i && (cnt_q == {W{1'b1}});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
      wrap_q <= 1'b0;
      tgl_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_now_o;
      tgl_q  <= cnt_d[0] ^ cnt_q[0];
      if (snap_i) snap_q <= cnt_q;  // pre-event value
    end
  end

  assign cnt_o     = cnt_q;
  assign snap_o    = snap_q;
  assign wrap_o    = wrap_q;
  assign lsb_tgl_o = tgl_q;

  assert_inc_by_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !clr_i |=> cnt_q == W'($past(cnt_q) + 1'b1));
  assert_clear_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);
  assert_snap_pre_event_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> snap_q == $past(cnt_q));
  assert_snap_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_i |=> $stable(snap_q));
  assert_wrap_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_q |-> cnt_q == '0);
endmodule

// File: rtl/e1_perf_counters.sv
module e1_perf_counters
  import e1pm_pkg::*;
#(
  parameter int FRAMES_PER_SEC = 8000,
  parameter int FAS_W  = 8,
  parameter int BPV_W  = 16,
  parameter int CRC_W  = 10,
  parameter int EBIT_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_strobe_i,
  input  logic              fas_err_i,
  input  logic              bpv_err_i,
  input  logic              crc_err_i,
  input  logic              ebit_err_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              fas_lsb_irq_o,
  output logic              fas_wrap_irq_o,
  output logic              bpv_wrap_irq_o,
  output logic              sec_irq_o
);
  localparam int CNT_W [N_CNT] = '{FAS_W, BPV_W, CRC_W, EBIT_W};

  logic              tick, sec_q;
  logic [N_CNT-1:0]  inc, clr, wrap_now, wrap, tgl;
  logic [N_CNT-1:0]  ovf_q;
  logic [DATA_W-1:0] live [N_CNT];
  logic [DATA_W-1:0] snap [N_CNT];
  logic              rd_ovf;

  assign inc = {ebit_err_i, crc_err_i, bpv_err_i, fas_err_i};

  e1pm_prescaler #(.FRAMES_PER_SEC(FRAMES_PER_SEC)) u_ps (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(frame_strobe_i), .tick_o(tick)
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    localparam int W = CNT_W[g];
    logic [W-1:0] lv, sv;
    assign clr[g] = reg_wr_i && (reg_addr_i == ADDR_W'(g));
    e1pm_counter #(.W(W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc[g]), .clr_i(clr[g]),
      .snap_i(tick), .cnt_o(lv), .snap_o(sv), .wrap_now_o(wrap_now[g]),
      .wrap_o(wrap[g]), .lsb_tgl_o(tgl[g])
    );
    assign live[g] = DATA_W'(lv);
    assign snap[g] = DATA_W'(sv);
  end

  assign rd_ovf = reg_rd_i && (reg_addr_i == ADDR_OVF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= '0;
      sec_q <= 1'b0;
    end else begin
      ovf_q <= (rd_ovf ? '0 : ovf_q) | wrap_now;  // new wrap beats clear
      sec_q <= tick;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i < ADDR_SNAP_BASE)
      reg_rdata_o = live[reg_addr_i[1:0]];
    else if (reg_addr_i < ADDR_OVF)
      reg_rdata_o = snap[reg_addr_i[1:0]];
    else if (reg_addr_i == ADDR_OVF)
      reg_rdata_o = DATA_W'(ovf_q);
  end

  assign fas_lsb_irq_o  = tgl[IDX_FAS];
  assign fas_wrap_irq_o = wrap[IDX_FAS];
  assign bpv_wrap_irq_o = wrap[IDX_BPV];
  assign sec_irq_o      = sec_q;

  assert_ovf_on_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap & ~ovf_q) == '0);
  assert_sec_from_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |-> $past(frame_strobe_i));
  assert_sec_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_q |=> !sec_q || FRAMES_PER_SEC == 1);
  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_ovf |=> (($past(ovf_q) & ~ovf_q) == '0));
endmodule

// File: tb/sim_e1_perf_counters.sv
`timescale 1ns/1ps
module sim_e1_perf_counters;
  localparam int FPS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 0, fas = 0, bpv = 0, crc = 0, ebit = 0;
  logic [3:0]  addr = '0;
  logic        rd = 0, wr = 0;
  logic [15:0] rdata;
  logic        lsb_irq, fwrap_irq, bwrap_irq, sec_irq;
  int          n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  e1_perf_counters #(.FRAMES_PER_SEC(FPS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_strobe_i(strobe),
    .fas_err_i(fas), .bpv_err_i(bpv), .crc_err_i(crc), .ebit_err_i(ebit),
    .reg_addr_i(addr), .reg_rd_i(rd), .reg_wr_i(wr), .reg_rdata_o(rdata),
    .fas_lsb_irq_o(lsb_irq), .fas_wrap_irq_o(fwrap_irq),
    .bpv_wrap_irq_o(bwrap_irq), .sec_irq_o(sec_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // holds the selected error inputs for n rising edges, then samples on the falling edge
  task automatic pulse(input logic [3:0] m, input int n, input logic stb);
    @(negedge clk);
    {ebit, crc, bpv, fas} = m; strobe = stb;
    repeat (n) @(negedge clk);
    {ebit, crc, bpv, fas} = '0; strobe = 0;
    #0.5;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #0.5; d = rdata;
  endtask

  task automatic wr_reg(input logic [3:0] a);
    @(negedge clk); addr = a; wr = 1;
    @(negedge clk); wr = 0; #0.5;
  endtask

  task automatic rd_ovf(output logic [15:0] d);
    @(negedge clk); addr = 4'd8; rd = 1; #0.5; d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 9; a++) begin
      rd_reg(4'(a), d); check("R1 reset reg", d, 0);
    end
    check("R1 irqs", {lsb_irq, fwrap_irq, bwrap_irq, sec_irq}, 0);
  endtask

  task automatic t_count;
    logic [15:0] d;
    pulse(4'b1111, 2, 0);
    pulse(4'b0111, 1, 0);
    pulse(4'b0101, 2, 0);
    pulse(4'b0100, 2, 0);
    rd_reg(0, d); check("R2 fas count", d, 5);
    rd_reg(1, d); check("R2 bpv count", d, 3);
    rd_reg(2, d); check("R2 crc count", d, 7);
    rd_reg(3, d); check("R2 ebit count", d, 2);
    rd_reg(9, d); check("R10 unused addr", d, 0);
  endtask

  task automatic t_clear;
    logic [15:0] d;
    wr_reg(1);
    check("R4 no toggle on other clear", lsb_irq, 0);
    rd_reg(1, d); check("R3 bpv cleared", d, 0);
    rd_reg(0, d); check("R3 fas untouched", d, 5);
    wr_reg(0);
    check("R4 toggle on clear", lsb_irq, 1);
    @(negedge clk); addr = 2; wr = 1; crc = 1;
    @(negedge clk); wr = 0; crc = 0;
    rd_reg(2, d); check("R3 clear beats event", d, 0);
    rd_reg(3, d); check("R3 ebit untouched", d, 2);
    wr_reg(4);
    rd_reg(4, d); check("R9 snapshot write ignored", d, 0);
  endtask

  task automatic t_fas_wrap;
    logic [15:0] d;
    pulse(4'b0001, 255, 0);
    check("R5 no early fas wrap", fwrap_irq, 0);
    check("R4 toggle on inc", lsb_irq, 1);
    pulse(4'b0001, 1, 0);
    check("R5 fas wrap irq", fwrap_irq, 1);
    rd_reg(0, d); check("R5 fas wraps to 0", d, 0);
    check("R5 fas wrap single cycle", fwrap_irq, 0);
    rd_ovf(d); check("R6 ovf fas bit", d, 16'h1);
    rd_reg(8, d); check("R6 ovf cleared on read", d, 0);
  endtask

  task automatic t_big_wraps;
    logic [15:0] d;
    pulse(4'b0010, 65536, 0);
    check("R5 bpv wrap irq", bwrap_irq, 1);
    rd_reg(1, d); check("R5 bpv wraps to 0", d, 0);
    rd_ovf(d); check("R6 ovf bpv bit", d, 16'h2);
    wr_reg(3);
    pulse(4'b1100, 1024, 0);
    rd_ovf(d); check("R6 ovf crc+ebit", d, 16'hC);
    pulse(4'b0100, 1023, 0);
    @(negedge clk); addr = 8; rd = 1; crc = 1; #0.5; d = rdata;
    check("R6 read before wrap", d, 0);
    @(negedge clk); rd = 0; crc = 0; #0.5;
    rd_reg(8, d); check("R6 wrap during read kept", d, 16'h4);
    rd_ovf(d);
  endtask

  task automatic t_snap;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) wr_reg(4'(a));
    pulse(4'b0001, 3, 0);
    pulse(4'b0010, 5, 0);
    pulse(4'b0000, FPS - 1, 1);
    check("R7 no tick before count", sec_irq, 0);
    pulse(4'b0001, 1, 1);
    check("R7 sec irq", sec_irq, 1);
    rd_reg(4, d); check("R8 fas snap excludes event", d, 3);
    check("R7 sec irq single cycle", sec_irq, 0);
    rd_reg(0, d); check("R8 live includes event", d, 4);
    rd_reg(5, d); check("R8 bpv snap", d, 5);
    rd_reg(6, d); check("R8 crc snap", d, 0);
    pulse(4'b0001, 2, 0);
    rd_reg(0, d); check("R9 live keeps running", d, 6);
    rd_reg(4, d); check("R9 snap holds", d, 3);
    pulse(4'b0000, FPS, 1);
    check("R7 second tick", sec_irq, 1);
    rd_reg(4, d); check("R9 snap updated", d, 6);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_count;
    t_clear;
    t_fas_wrap;
    t_big_wraps;
    t_snap;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule